// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block drives sixteen general-purpose pins and is reached over a simple word-addressed register bus. Each pin gets a 4-bit code. Its two low bits pick input or output, and set the drive speed when the pin is an output. Its two high bits pick the flavour of input or output: analog, floating or pulled for an input, and push-pull or open-drain, general or alternate-function, for an output. For each pin the block produces an output enable, the output level, an open-drain select, pull-up and pull-down enables, an alternate-function select and a 2-bit speed code. The pad logic around it turns these into electrical behaviour.

The output data register can be written in three ways. A plain write loads every bit. A combined register sets some bits and clears others in one write. A clear-only register clears bits. A write-one-to-act register leaves untouched the bits a caller is not working on, so no read-modify-write is needed. For a pulled input, the same output data bit chooses the pull direction. Pad levels pass through a two-flop synchronizer before they can be read back. Software can freeze chosen pin codes with a keyed lock sequence. The freeze holds until the next reset.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset both configuration words read 0x44444444 (code 4'b0100 = floating input on every pin), the output data and lock words read 0, and every pin output (enable, open-drain, pulls, alternate select, speed) is 0.
- R2: Word address 0 holds the codes of pins 0-7 and address 1 those of pins 8-15. Pin n uses bits [4*(n%8)+3 : 4*(n%8)] as {cfg[1:0], mode[1:0]}. A nonzero mode makes the pin an output (enable 1) with speed code equal to mode (1, 2, 3 = slow, medium, fast). Mode 0 gives enable 0 and speed 0.
- R3: For an output pin, cfg[0]=1 selects open-drain, cfg[1]=1 selects the alternate function, and the pin level equals its output data bit.
- R4: For an input pin, cfg=2'b10 enables the pull-up when the pin's output data bit is 1 and the pull-down when it is 0. cfg 2'b00 (analog), 2'b01 (floating) and 2'b11 (reserved) enable no pull, no open-drain and no alternate select. A pin never has a pull enabled while it drives, and never has both pulls enabled.
- R5: A write to address 3 loads output data bits [15:0] from the write data.
- R6: A write to address 4 sets the output bits marked by 1s in data[15:0] and clears those marked in data[31:16]. A 0 bit changes nothing. When both halves mark the same bit, that bit ends at 1.
- R7: A write to address 5 clears the output bits marked by 1s in data[15:0]. Other bits keep their value.
- R8: Address 2 returns the pad levels in bits [15:0] and ignores writes. A pad change is visible there after the second rising clock edge and not after the first.
- R9: At address 6, bits [15:0] hold the lock mask and bit 16 is the key. The pin codes selected by the mask lock after these accesses to address 6, in this order: a write with key 1, a write with key 0, a write with key 1 (all three with the same mask), then a read. That read, and every later read, returns bit 16 = 1.
- R10: A change of mask, a wrong key value, or a read before the third write abandons the lock sequence. Bit 16 then reads 0 and all pin codes stay writable.
- R11: While locked, writes leave the codes of masked pins unchanged and still update unmasked pins. Writes to address 6 no longer change it.
- R12: Address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used by the lock key sequence) |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Output level per pin |
| pad_oe | output | 16 | Output enable per pin |
| pad_od | output | 16 | Open-drain select per pin |
| pad_pu | output | 16 | Pull-up enable per pin |
| pad_pd | output | 16 | Pull-down enable per pin |
| pad_af | output | 16 | Alternate-function select per pin |
| pad_speed | output | 32 | Speed code, pin n at [2n+1:2n] |

## Verification
Random configuration words cover all sixteen codes on every pin. They are mixed with random output data, so the same code is seen with both data values. This exposes a swapped pull direction or a pull or open-drain leaking into the wrong direction. Plain, set/clear and clear-only writes are interleaved with random masks, and a directed overlapping set/clear write shows which side has priority. The lock is tried with a mask change, an early read and a clean sequence. Locked, unlocked and lock-register writes after the lock tell apart per-pin freezing, whole-port freezing and no freezing. The input path is sampled one and two edges after a pad change, which checks the synchronizer depth.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // word addresses on the register bus
  typedef enum logic [2:0] {
    REG_CFG_LO = 3'd0,
    REG_CFG_HI = 3'd1,
    REG_IN     = 3'd2,
    REG_OUT    = 3'd3,
    REG_SETCLR = 3'd4,
    REG_CLR    = 3'd5,
    REG_LOCK   = 3'd6
  } gp_reg_e;

  // per-pin control bundle handed to the pad ring
  typedef struct packed {
    logic       oe;
    logic       od;
    logic       af;
    logic       pu;
    logic       pd;
    logic [1:0] speed;
  } pin_ctl_t;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_ONE   = 2'd1,
    LK_ZERO  = 2'd2,
    LK_ARMED = 2'd3
  } lk_state_e;

  localparam logic [3:0] CODE_FLOAT_IN = 4'b0100;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_async;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

  // R8
  sync_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage_q[STAGES-1] == $past(stage_q[STAGES-2])));

endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lk,
  input  logic             rd_lk,
  input  logic             key_bit,
  input  logic [NPINS-1:0] mask_in,
  output logic [NPINS-1:0] mask_view,
  output logic             key_view,
  output logic [NPINS-1:0] lock_mask
);

  lk_state_e        state_q, state_d;
  logic             locked_q, locked_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic             mask_en;
  logic             same_mask;

  assign same_mask = (mask_in == mask_q);
  assign mask_en   = wr_lk && !locked_q;

  always_comb begin
    state_d  = state_q;
    locked_d = locked_q;
    mask_d   = mask_in;
    if (!locked_q) begin
      unique case (state_q)
        LK_IDLE: begin
          if (wr_lk && key_bit) state_d = LK_ONE;
        end
        LK_ONE: begin
          if (wr_lk)      state_d = (!key_bit && same_mask) ? LK_ZERO : LK_IDLE;
          else if (rd_lk) state_d = LK_IDLE;
        end
        LK_ZERO: begin
          if (wr_lk)      state_d = (key_bit && same_mask) ? LK_ARMED : LK_IDLE;
          else if (rd_lk) state_d = LK_IDLE;
        end
        LK_ARMED: begin
          if (rd_lk) begin
            locked_d = 1'b1;
            state_d  = LK_IDLE;
          end else if (wr_lk) begin
            state_d = LK_IDLE;
          end
        end
        default: state_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LK_IDLE;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      locked_q <= locked_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_view = mask_q;
  assign key_view  = locked_q || (state_q == LK_ARMED);
  assign lock_mask = locked_q ? mask_q : '0;

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> (locked_q && $stable(mask_q)));

  // R10
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(state_q == LK_ARMED && rd_lk));

endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
  import gpio_port_pkg::*;
(
  input  logic [3:0] code,
  input  logic       data_bit,
  output pin_ctl_t   ctl
);

  logic [1:0] mode;
  logic [1:0] flavour;
  logic       is_out;
  logic       pulled;

  assign mode    = code[1:0];
  assign flavour = code[3:2];
  assign is_out  = (mode != 2'b00);
  assign pulled  = !is_out && (flavour == 2'b10);

  always_comb begin
    ctl.oe    = is_out;
    ctl.speed = mode;
    ctl.od    = is_out && flavour[0];
    ctl.af    = is_out && flavour[1];
    ctl.pu    = pulled && data_bit;
    ctl.pd    = pulled && !data_bit;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_od,
  output logic [NPINS-1:0]   pad_pu,
  output logic [NPINS-1:0]   pad_pd,
  output logic [NPINS-1:0]   pad_af,
  output logic [2*NPINS-1:0] pad_speed
);

  localparam int unsigned CFG_W  = 4 * NPINS;
  localparam int unsigned HALF_W = CFG_W / 2;
  localparam logic [CFG_W-1:0] CFG_RST = {NPINS{CODE_FLOAT_IN}};

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // access decode
  logic wr_lo, wr_hi, wr_out, wr_sc, wr_clr, wr_lk, rd_lk;
  assign wr_lo  = wr_en && (addr == REG_CFG_LO);
  assign wr_hi  = wr_en && (addr == REG_CFG_HI);
  assign wr_out = wr_en && (addr == REG_OUT);
  assign wr_sc  = wr_en && (addr == REG_SETCLR);
  assign wr_clr = wr_en && (addr == REG_CLR);
  assign wr_lk  = wr_en && (addr == REG_LOCK);
  assign rd_lk  = rd_en && !wr_en && (addr == REG_LOCK);

  // lock
  logic [NPINS-1:0] lock_mask, lk_mask_view;
  logic             lk_key_view;

  gpio_lock_ctrl #(.NPINS(NPINS)) u_lock (
    .clk       (clk),
    .rst_n     (rst_s),
    .wr_lk     (wr_lk),
    .rd_lk     (rd_lk),
    .key_bit   (wdata[NPINS]),
    .mask_in   (wdata[NPINS-1:0]),
    .mask_view (lk_mask_view),
    .key_view  (lk_key_view),
    .lock_mask (lock_mask)
  );

  logic [CFG_W-1:0] lock_bits;
  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_lockbits
      assign lock_bits[4*gi +: 4] = {4{lock_mask[gi]}};
    end
  endgenerate

  // configuration words
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;

  assign cfg_en = wr_lo || wr_hi;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_lo)
      cfg_d[HALF_W-1:0] = (cfg_q[HALF_W-1:0] & lock_bits[HALF_W-1:0])
                        | (wdata[HALF_W-1:0] & ~lock_bits[HALF_W-1:0]);
    if (wr_hi)
      cfg_d[CFG_W-1:HALF_W] = (cfg_q[CFG_W-1:HALF_W] & lock_bits[CFG_W-1:HALF_W])
                            | (wdata[HALF_W-1:0] & ~lock_bits[CFG_W-1:HALF_W]);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      cfg_q <= CFG_RST;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // output data
  logic [NPINS-1:0] odr_q, odr_d;
  logic             odr_en;
  logic [NPINS-1:0] set_bits, clr_bits;

  assign set_bits = wdata[NPINS-1:0];
  assign clr_bits = wdata[2*NPINS-1:NPINS];
  assign odr_en   = wr_out || wr_sc || wr_clr;

  always_comb begin
    odr_d = odr_q;
    if (wr_out)      odr_d = set_bits;
    else if (wr_sc)  odr_d = (odr_q & ~clr_bits) | set_bits;
    else if (wr_clr) odr_d = odr_q & ~set_bits;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      odr_q <= '0;
    else if (odr_en) odr_q <= odr_d;
  end

  // input path
  logic [NPINS-1:0] idr;

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_s),
    .d_async (pad_in),
    .q_sync  (idr)
  );

  // per-pin decode
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_pin
      pin_ctl_t ctl;
      gpio_pin_decode u_dec (
        .code     (cfg_q[4*gi +: 4]),
        .data_bit (odr_q[gi]),
        .ctl      (ctl)
      );
      assign pad_oe[gi]              = ctl.oe;
      assign pad_od[gi]              = ctl.od;
      assign pad_af[gi]              = ctl.af;
      assign pad_pu[gi]              = ctl.pu;
      assign pad_pd[gi]              = ctl.pd;
      assign pad_speed[2*gi +: 2]    = ctl.speed;

      // R4
      no_pull_when_driven_chk: assert property (@(posedge clk) disable iff (!rst_s)
        !(pad_oe[gi] && (pad_pu[gi] || pad_pd[gi])));
      // R4
      single_pull_chk: assert property (@(posedge clk) disable iff (!rst_s)
        $countones({pad_pu[gi], pad_pd[gi]}) <= 1);
    end
  endgenerate

  assign pad_out = odr_q;

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_CFG_LO: rdata[HALF_W-1:0] = cfg_q[HALF_W-1:0];
      REG_CFG_HI: rdata[HALF_W-1:0] = cfg_q[CFG_W-1:HALF_W];
      REG_IN:     rdata[NPINS-1:0]  = idr;
      REG_OUT:    rdata[NPINS-1:0]  = odr_q;
      REG_LOCK: begin
        rdata[NPINS-1:0] = lk_mask_view;
        rdata[NPINS]     = lk_key_view;
      end
      default:    rdata = '0;
    endcase
  end

  // R11
  locked_field_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> ((cfg_q & $past(lock_bits)) == ($past(cfg_q) & $past(lock_bits))));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_s)
    wr_sc |=> ((odr_q & $past(set_bits)) == $past(set_bits)));

  // R7
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_s)
    wr_clr |=> ((odr_q & $past(set_bits)) == '0));

endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/100ps
module gpio_port_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [15:0] pad_in, pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_af;
  logic [31:0] pad_speed;

  int total = 0;
  int bad   = 0;

  logic [63:0] m_cfg;
  logic [15:0] m_odr, m_lkmask;
  logic        m_locked;

  always #2 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_af(pad_af), .pad_speed(pad_speed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {oe, od, af, pu, pd, speed[1:0]}
  function automatic logic [6:0] pin_exp(input logic [3:0] c, input logic d);
    logic out;
    out = (c[1:0] != 2'b00);
    if (out) return {1'b1, c[2], c[3], 1'b0, 1'b0, c[1:0]};
    if (c[3:2] == 2'b10) return {3'b000, d, ~d, 2'b00};
    return 7'd0;
  endfunction

  function automatic void model_wr(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: for (int i = 0; i < 8; i++)
              if (!(m_locked && m_lkmask[i])) m_cfg[4*i +: 4] = d[4*i +: 4];
      3'd1: for (int i = 8; i < 16; i++)
              if (!(m_locked && m_lkmask[i])) m_cfg[4*i +: 4] = d[4*(i-8) +: 4];
      3'd3: m_odr = d[15:0];
      3'd4: m_odr = (m_odr & ~d[31:16]) | d[15:0];
      3'd5: m_odr = m_odr & ~d[15:0];
      3'd6: if (!m_locked) m_lkmask = d[15:0];
      default: ;
    endcase
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_lock(output logic [31:0] v);
    @(negedge clk);
    addr = 3'd6; rd_en = 1'b1;
    #0.2 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_state(input string req);
    logic [15:0] e_oe, e_od, e_af, e_pu, e_pd;
    logic [31:0] e_sp;
    addr = 3'd0; #0.2 chk({req, " cfg_lo"}, rdata, m_cfg[31:0]);
    addr = 3'd1; #0.2 chk({req, " cfg_hi"}, rdata, m_cfg[63:32]);
    addr = 3'd3; #0.2 chk({req, " out"}, rdata, {16'd0, m_odr});
    addr = 3'd6; #0.2 chk({req, " lock"}, rdata, {15'd0, m_locked, m_lkmask});
    for (int i = 0; i < 16; i++) begin
      logic [6:0] p;
      p = pin_exp(m_cfg[4*i +: 4], m_odr[i]);
      {e_oe[i], e_od[i], e_af[i], e_pu[i], e_pd[i], e_sp[2*i +: 2]} = p;
    end
    chk({req, " oe R2"}, {16'd0, pad_oe}, {16'd0, e_oe});
    chk({req, " speed R2"}, pad_speed, e_sp);
    chk({req, " od R3"}, {16'd0, pad_od}, {16'd0, e_od});
    chk({req, " af R3"}, {16'd0, pad_af}, {16'd0, e_af});
    chk({req, " level R3"}, {16'd0, pad_out}, {16'd0, m_odr});
    chk({req, " pu R4"}, {16'd0, pad_pu}, {16'd0, e_pu});
    chk({req, " pd R4"}, {16'd0, pad_pd}, {16'd0, e_pd});
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] pv;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 3'd0; wdata = '0; pad_in = '0;
    m_cfg = {16{4'b0100}}; m_odr = '0; m_lkmask = '0; m_locked = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_state("R1");

    // R12 unused address
    addr = 3'd7; #0.2 chk("R12 unused addr", rdata, 32'd0);

    // R2 R3 R4 directed: every code on one half, both data values
    wr(3'd0, 32'hFEDC_BA98); wr(3'd1, 32'h7654_3210);
    wr(3'd3, 32'h0000_0000); check_state("R2 R3 R4 data0");
    wr(3'd3, 32'h0000_FFFF); check_state("R2 R3 R4 data1");

    // R6 overlapping set and clear: set wins
    wr(3'd3, 32'h0000_00FF);
    wr(3'd4, 32'hFFFF_0F0F);
    addr = 3'd3; #0.2 chk("R6 set wins", rdata, 32'h0000_0F0F);
    wr(3'd4, 32'h0000_0000);
    addr = 3'd3; #0.2 chk("R6 zero no effect", rdata, 32'h0000_0F0F);
    // R7 clear only
    wr(3'd5, 32'hFFFF_0003);
    addr = 3'd3; #0.2 chk("R7 clear only", rdata, 32'h0000_0F0C);
    // R5 plain load
    wr(3'd3, 32'hABCD_1234);
    addr = 3'd3; #0.2 chk("R5 load", rdata, 32'h0000_1234);

    // R8 sync depth and write-ignore
    @(negedge clk); pad_in = 16'hA55A;
    @(negedge clk); addr = 3'd2; #0.2 chk("R8 one edge", rdata, 32'h0000_0000);
    @(negedge clk); addr = 3'd2; #0.2 chk("R8 two edges", rdata, 32'h0000_A55A);
    wr(3'd2, 32'h0000_0000);
    addr = 3'd2; #0.2 chk("R8 write ignored", rdata, 32'h0000_A55A);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      logic [31:0] d;
      op = $urandom % 6;
      d  = $urandom;
      case (op)
        0: wr(3'd0, d);
        1: wr(3'd1, d);
        2: wr(3'd3, d);
        3: wr(3'd4, d);
        4: wr(3'd5, d);
        default: begin
          pv = d[15:0];
          @(negedge clk); pad_in = pv;
          repeat (2) @(negedge clk);
          addr = 3'd2; #0.2 chk("R8 random pads", rdata, {16'd0, pv});
        end
      endcase
      check_state("R5 R6 R7 random");
    end

    // R10 abort by mask change
    wr(3'd6, 32'h0001_00F0); wr(3'd6, 32'h0000_00F0); wr(3'd6, 32'h0001_00F1);
    rd_lock(v);
    chk("R10 mask change key", {31'd0, v[16]}, 32'd0);
    wr(3'd0, 32'h1111_1111); wr(3'd1, 32'h2222_2222);
    check_state("R10 still writable");

    // R10 abort by early read
    wr(3'd6, 32'h0001_0003);
    rd_lock(v);
    chk("R10 early read key", {31'd0, v[16]}, 32'd0);
    wr(3'd6, 32'h0000_0003); wr(3'd6, 32'h0001_0003);
    rd_lock(v);
    chk("R10 broken order key", {31'd0, v[16]}, 32'd0);
    wr(3'd0, 32'h3333_3333);
    check_state("R10 order");

    // R9 clean sequence
    wr(3'd6, 32'h0001_80F1); wr(3'd6, 32'h0000_80F1); wr(3'd6, 32'h0001_80F1);
    rd_lock(v);
    chk("R9 completing read", v, 32'h0001_80F1);
    m_locked = 1'b1;
    rd_lock(v);
    chk("R9 later read", v, 32'h0001_80F1);

    // R11 locked pins frozen, lock register frozen
    wr(3'd6, 32'h0000_0000);
    check_state("R11 lock reg frozen");
    for (int n = 0; n < 40; n++) begin
      wr(($urandom % 2 == 0) ? 3'd0 : 3'd1, $urandom);
      check_state("R11 locked writes");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule